// File: doc/BRIEF.md
# Hardware Lock Unit for Short Critical Sections

This block holds a small set of lock bits that several processing elements share. Each processor reaches the unit through its own narrow request port with ordinary load and store operations, so neither the core nor its caches need atomic instructions. A load of a lock address is the acquire. If the lock is free, the load takes it for that processor and returns 1. If another processor holds it, the load returns 0 and the processor is recorded as waiting. A store from the holder releases the lock.

When a lock with waiters is released, the unit picks one waiter in round-robin order, starting after the processor that just released it. It sends that waiter a one-cycle interrupt and removes it from the waiting set. The lock itself is not handed over. It stays free until a processor reads it, so the woken processor reads again to take it. Locks belong to processors rather than to tasks, which suits short critical sections where a waiting processor does not switch tasks.

Top module: `hw_lock_unit`

## Requirements
- R1: After reset every lock is free and all four outputs are zero; the first read of any lock is granted.
- R2: A read of a free lock makes `rsp_valid` and `rsp_grant` 1 for that processor on the cycle after the request, and the lock becomes held by that processor.
- R3: A read of a lock held by another processor returns `rsp_valid`=1 and `rsp_grant`=0, and records the reader as waiting on that lock.
- R4: A read of a held lock by its current holder returns a grant and changes neither the holder nor the waiting set.
- R5: When several processors read the same free lock in one cycle, only the lowest processor index is granted. Every other reader gets 0 and is recorded as waiting.
- R6: A store from the holder frees the lock. If nobody is waiting, no interrupt follows and the next reader of that lock is granted.
- R7: A store from a processor that does not hold the lock, including a store to a free lock, leaves the lock unchanged and pulses `wr_err` for that processor for one cycle, on the cycle after the store.
- R8: A release with waiters pulses `wake_irq` for exactly one processor for exactly one cycle, on the cycle after the store. That processor is the first waiter found by searching upward from the releasing holder's index plus one, wrapping past the top index. The chosen processor stops being a waiter.
- R9: After a wake-up the lock is free and reserved for no one: the first later reader is granted, and the remaining waiters are woken on later releases.
- R10: Locks are independent. Operations on one lock leave the holder and waiters of every other lock unchanged.
- R11: `rsp_valid` is high for exactly the cycles that follow cycles with a read request, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_en | input | NPROC | Per-processor acquire (load) request |
| wr_en | input | NPROC | Per-processor release (store) request |
| addr | input | NPROC*clog2(NLOCK) | Per-processor lock index; processor p occupies field p |
| rsp_valid | output | NPROC | Read response present, one cycle after the read |
| rsp_grant | output | NPROC | Read result: 1 means the lock is now held by this processor |
| wake_irq | output | NPROC | One-cycle wake-up interrupt to the chosen waiter |
| wr_err | output | NPROC | One-cycle flag for a store that was not a valid release |

## Verification
The assertions assume that each processor presents at most one operation per cycle, either a read or a store but never both. They also assume every lock index is below NLOCK. If a processor does present both, the design treats it as a read. The stimulus comes from directed tasks that give each processor a single operation per cycle and use only indices 0 to 7. Simultaneous activity is limited to several processors reading one lock, or different processors touching different locks.

// File: rtl/hw_lock_pkg.sv
package hw_lock_pkg;
  localparam int VEC_W = 32;
  typedef logic [VEC_W-1:0] vec_t;

  // keep only the lowest set bit
  function automatic vec_t lowest_onehot(vec_t v);
    return v & (~v + vec_t'(1));
  endfunction

  // first set bit of v searched upward from start+1, wrapping modulo n
  function automatic vec_t rr_onehot(vec_t v, int start, int n);
    vec_t r;
    r = '0;
    for (int k = n; k >= 1; k--) begin
      int idx;
      idx = (start + k) % n;
      if (v[idx]) r = vec_t'(1) << idx;
    end
    return r;
  endfunction

  // position of the highest set bit (input is one-hot where used)
  function automatic int onehot_index(vec_t v);
    int r;
    r = 0;
    for (int i = 0; i < VEC_W; i++)
      if (v[i]) r = i;
    return r;
  endfunction
endpackage

// File: rtl/hw_lock_decode.sv
module hw_lock_decode #(
  parameter int NPROC = 4,
  parameter int NLOCK = 8
) (
  input  logic [NPROC-1:0]                    rd_en,
  input  logic [NPROC-1:0]                    wr_en,
  input  logic [NPROC*$clog2(NLOCK)-1:0]      addr,
  output logic [NLOCK-1:0][NPROC-1:0]         rd_hit,
  output logic [NLOCK-1:0][NPROC-1:0]         wr_hit
);
  localparam int AW = $clog2(NLOCK);

  always_comb begin
    for (int l = 0; l < NLOCK; l++) begin
      for (int p = 0; p < NPROC; p++) begin
        logic sel;
        sel = (addr[p*AW +: AW] == AW'(l));
        rd_hit[l][p] = rd_en[p] & sel;
        // a read in the same cycle takes precedence over a store
        wr_hit[l][p] = wr_en[p] & ~rd_en[p] & sel;
      end
    end
  end
endmodule

// File: rtl/hw_lock_slot.sv
module hw_lock_slot
  import hw_lock_pkg::*;
#(
  parameter int NPROC = 4
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [NPROC-1:0]                    rd_hit,
  input  logic [NPROC-1:0]                    wr_hit,
  output logic                                held_o,
  output logic [((NPROC > 1) ? $clog2(NPROC) : 1)-1:0] owner_o,
  output logic [NPROC-1:0]                    pend_o,
  output logic [NPROC-1:0]                    grant_o,
  output logic [NPROC-1:0]                    bad_o,
  output logic [NPROC-1:0]                    wake_o,
  output logic                                release_o
);
  localparam int PW = (NPROC > 1) ? $clog2(NPROC) : 1;

  logic             held_q;
  logic [PW-1:0]    owner_q;
  logic [NPROC-1:0] pend_q;
  logic [NPROC-1:0] own_vec;
  logic [NPROC-1:0] new_wait;
  logic [NPROC-1:0] waiters;
  logic [NPROC-1:0] pend_n;
  logic             take_free;
  vec_t             tmp_own;
  vec_t             tmp_low;
  vec_t             tmp_rr;

  always_comb begin
    tmp_own = vec_t'(1) << owner_q;
    own_vec = held_q ? tmp_own[NPROC-1:0] : '0;
    tmp_low = lowest_onehot(vec_t'(rd_hit));
    if (held_q) begin
      grant_o  = rd_hit & own_vec;
      new_wait = rd_hit & ~own_vec;
    end else begin
      grant_o  = tmp_low[NPROC-1:0];
      new_wait = rd_hit & ~tmp_low[NPROC-1:0];
    end
    release_o = held_q & |(wr_hit & own_vec);
    bad_o     = wr_hit & ~own_vec;
    waiters   = pend_q | new_wait;
    tmp_rr    = rr_onehot(vec_t'(waiters), int'(owner_q), NPROC);
    wake_o    = release_o ? tmp_rr[NPROC-1:0] : '0;
    pend_n    = waiters & ~wake_o & ~grant_o;
    take_free = ~held_q & |grant_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q  <= 1'b0;
      owner_q <= '0;
      pend_q  <= '0;
    end else begin
      pend_q <= pend_n;
      if (take_free) begin
        held_q  <= 1'b1;
        owner_q <= PW'(onehot_index(vec_t'(grant_o)));
      end else if (release_o) begin
        held_q <= 1'b0;
      end
    end
  end

  assign held_o  = held_q;
  assign owner_o = owner_q;
  assign pend_o  = pend_q;
endmodule

// File: rtl/hw_lock_unit.sv
module hw_lock_unit #(
  parameter int NPROC = 4,
  parameter int NLOCK = 8
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [NPROC-1:0]                   rd_en,
  input  logic [NPROC-1:0]                   wr_en,
  input  logic [NPROC*$clog2(NLOCK)-1:0]     addr,
  output logic [NPROC-1:0]                   rsp_valid,
  output logic [NPROC-1:0]                   rsp_grant,
  output logic [NPROC-1:0]                   wake_irq,
  output logic [NPROC-1:0]                   wr_err
);
  localparam int PW = (NPROC > 1) ? $clog2(NPROC) : 1;

  logic [NLOCK-1:0][NPROC-1:0] rd_hit;
  logic [NLOCK-1:0][NPROC-1:0] wr_hit;

  // per-lock internal events, named for the checker
  logic [NLOCK-1:0]            slot_held;
  logic [NLOCK-1:0][PW-1:0]    slot_owner;
  logic [NLOCK-1:0][NPROC-1:0] slot_pend;
  logic [NLOCK-1:0][NPROC-1:0] slot_grant;
  logic [NLOCK-1:0][NPROC-1:0] slot_bad;
  logic [NLOCK-1:0][NPROC-1:0] slot_wake;
  logic [NLOCK-1:0]            slot_release;

  logic [NPROC-1:0] grant_any;
  logic [NPROC-1:0] wake_any;
  logic [NPROC-1:0] bad_any;

  hw_lock_decode #(.NPROC(NPROC), .NLOCK(NLOCK)) u_dec (
    .rd_en  (rd_en),
    .wr_en  (wr_en),
    .addr   (addr),
    .rd_hit (rd_hit),
    .wr_hit (wr_hit)
  );

  for (genvar l = 0; l < NLOCK; l++) begin : g_slot
    hw_lock_slot #(.NPROC(NPROC)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_hit    (rd_hit[l]),
      .wr_hit    (wr_hit[l]),
      .held_o    (slot_held[l]),
      .owner_o   (slot_owner[l]),
      .pend_o    (slot_pend[l]),
      .grant_o   (slot_grant[l]),
      .bad_o     (slot_bad[l]),
      .wake_o    (slot_wake[l]),
      .release_o (slot_release[l])
    );
  end

  always_comb begin
    grant_any = '0;
    wake_any  = '0;
    bad_any   = '0;
    for (int l = 0; l < NLOCK; l++) begin
      grant_any = grant_any | slot_grant[l];
      wake_any  = wake_any  | slot_wake[l];
      bad_any   = bad_any   | slot_bad[l];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= '0;
      rsp_grant <= '0;
      wake_irq  <= '0;
      wr_err    <= '0;
    end else begin
      rsp_valid <= rd_en;
      rsp_grant <= grant_any;
      wake_irq  <= wake_any;
      wr_err    <= bad_any;
    end
  end
endmodule

// File: rtl/hw_lock_unit_chk.sv
module hw_lock_unit_chk #(
  parameter int NPROC = 4,
  parameter int NLOCK = 8
) (
  input logic                                          clk,
  input logic                                          rst_n,
  input logic [NPROC-1:0]                              rd_en,
  input logic [NPROC-1:0]                              wr_en,
  input logic [NPROC-1:0]                              rsp_valid,
  input logic [NPROC-1:0]                              rsp_grant,
  input logic [NPROC-1:0]                              wr_err,
  input logic [NLOCK-1:0]                              slot_held,
  input logic [NLOCK-1:0][((NPROC > 1) ? $clog2(NPROC) : 1)-1:0] slot_owner,
  input logic [NLOCK-1:0][NPROC-1:0]                   slot_pend,
  input logic [NLOCK-1:0][NPROC-1:0]                   slot_grant,
  input logic [NLOCK-1:0][NPROC-1:0]                   slot_wake,
  input logic [NLOCK-1:0]                              slot_release
);
  for (genvar p = 0; p < NPROC; p++) begin : g_proc
    a_r11_valid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en[p] |=> rsp_valid[p]);
    a_r11_no_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en[p] |=> !rsp_valid[p]);
    a_r2_grant_has_valid: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_grant[p] |-> rsp_valid[p]);
    a_r7_err_from_store: assert property (@(posedge clk) disable iff (!rst_n)
      wr_err[p] |-> $past(wr_en[p]));
  end

  for (genvar l = 0; l < NLOCK; l++) begin : g_lock
    a_r5_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(slot_grant[l]));
    a_r8_one_wake: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(slot_wake[l]));
    a_r8_wake_needs_release: assert property (@(posedge clk) disable iff (!rst_n)
      (|slot_wake[l]) |-> slot_release[l]);
    a_r6_release_frees: assert property (@(posedge clk) disable iff (!rst_n)
      slot_release[l] |=> !slot_held[l]);
    a_r4_holder_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_held[l] && !slot_release[l]) |=> (slot_held[l] && $stable(slot_owner[l])));
    for (genvar p = 0; p < NPROC; p++) begin : g_wp
      a_r8_woken_not_waiting: assert property (@(posedge clk) disable iff (!rst_n)
        slot_wake[l][p] |=> !slot_pend[l][p]);
    end
  end
endmodule

bind hw_lock_unit hw_lock_unit_chk #(.NPROC(NPROC), .NLOCK(NLOCK)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rd_en        (rd_en),
  .wr_en        (wr_en),
  .rsp_valid    (rsp_valid),
  .rsp_grant    (rsp_grant),
  .wr_err       (wr_err),
  .slot_held    (slot_held),
  .slot_owner   (slot_owner),
  .slot_pend    (slot_pend),
  .slot_grant   (slot_grant),
  .slot_wake    (slot_wake),
  .slot_release (slot_release)
);

// File: tb/sim_hw_lock_unit.sv
`timescale 1ns/1ps
module sim_hw_lock_unit;
  localparam int NPROC = 4;
  localparam int NLOCK = 8;
  localparam int AW    = $clog2(NLOCK);

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic [NPROC-1:0]      rd_en = '0;
  logic [NPROC-1:0]      wr_en = '0;
  logic [NPROC*AW-1:0]   addr  = '0;
  logic [NPROC-1:0]      rsp_valid, rsp_grant, wake_irq, wr_err;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  hw_lock_unit #(.NPROC(NPROC), .NLOCK(NLOCK)) u0 (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .rsp_valid(rsp_valid), .rsp_grant(rsp_grant), .wake_irq(wake_irq), .wr_err(wr_err)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act[NPROC-1:0], exp[NPROC-1:0]);
    end
  endtask

  task automatic rd(input int p, input int l);
    rd_en[p] = 1'b1;
    addr[p*AW +: AW] = AW'(l);
  endtask

  task automatic wr(input int p, input int l);
    wr_en[p] = 1'b1;
    addr[p*AW +: AW] = AW'(l);
  endtask

  // wait one cycle, compare the four outputs, then drop all requests
  task automatic cyc(input string tag, input logic [3:0] v, input logic [3:0] g,
                     input logic [3:0] w, input logic [3:0] e);
    @(negedge clk);
    chk(tag, "rsp_valid", 32'(rsp_valid), 32'(v));
    chk(tag, "rsp_grant", 32'(rsp_grant), 32'(g));
    chk(tag, "wake_irq",  32'(wake_irq),  32'(w));
    chk(tag, "wr_err",    32'(wr_err),    32'(e));
    rd_en = '0;
    wr_en = '0;
  endtask

  task automatic t_reset();
    chk("R1", "rsp_valid", 32'(rsp_valid), 0);
    chk("R1", "rsp_grant", 32'(rsp_grant), 0);
    chk("R1", "wake_irq",  32'(wake_irq),  0);
    chk("R1", "wr_err",    32'(wr_err),    0);
    rd(0, 0); cyc("R1", 4'b0001, 4'b0001, 4'b0000, 4'b0000);
    wr(0, 0); cyc("R1", 4'b0000, 4'b0000, 4'b0000, 4'b0000);
  endtask

  task automatic t_hold_and_wake();
    rd(1, 3); cyc("R2",  4'b0010, 4'b0010, 4'b0000, 4'b0000);
    cyc("R11", 4'b0000, 4'b0000, 4'b0000, 4'b0000);
    rd(1, 3); cyc("R4",  4'b0010, 4'b0010, 4'b0000, 4'b0000);
    rd(2, 3); cyc("R3",  4'b0100, 4'b0000, 4'b0000, 4'b0000);
    wr(0, 3); cyc("R7",  4'b0000, 4'b0000, 4'b0000, 4'b0001);
    rd(0, 3); cyc("R7",  4'b0001, 4'b0000, 4'b0000, 4'b0000);
    wr(1, 3); cyc("R8",  4'b0000, 4'b0000, 4'b0100, 4'b0000);
    cyc("R8", 4'b0000, 4'b0000, 4'b0000, 4'b0000);
    rd(2, 3); cyc("R9",  4'b0100, 4'b0100, 4'b0000, 4'b0000);
    wr(2, 3); cyc("R8",  4'b0000, 4'b0000, 4'b0001, 4'b0000);
    rd(0, 3); cyc("R9",  4'b0001, 4'b0001, 4'b0000, 4'b0000);
    wr(0, 3); cyc("R6",  4'b0000, 4'b0000, 4'b0000, 4'b0000);
    rd(3, 3); cyc("R6",  4'b1000, 4'b1000, 4'b0000, 4'b0000);
    wr(3, 3); cyc("R6",  4'b0000, 4'b0000, 4'b0000, 4'b0000);
  endtask

  task automatic t_wrap_and_steal();
    rd(3, 7); cyc("R2", 4'b1000, 4'b1000, 4'b0000, 4'b0000);
    rd(2, 7); rd(0, 7); cyc("R3", 4'b0101, 4'b0000, 4'b0000, 4'b0000);
    wr(3, 7); cyc("R8", 4'b0000, 4'b0000, 4'b0001, 4'b0000);
    rd(1, 7); cyc("R9", 4'b0010, 4'b0010, 4'b0000, 4'b0000);
    wr(1, 7); cyc("R8", 4'b0000, 4'b0000, 4'b0100, 4'b0000);
    rd(2, 7); cyc("R9", 4'b0100, 4'b0100, 4'b0000, 4'b0000);
    wr(2, 7); cyc("R9", 4'b0000, 4'b0000, 4'b0000, 4'b0000);
  endtask

  task automatic t_tie();
    rd(1, 5); rd(2, 5); rd(3, 5);
    cyc("R5", 4'b1110, 4'b0010, 4'b0000, 4'b0000);
    wr(1, 5); cyc("R5", 4'b0000, 4'b0000, 4'b0100, 4'b0000);
    rd(2, 5); cyc("R5", 4'b0100, 4'b0100, 4'b0000, 4'b0000);
    wr(2, 5); cyc("R5", 4'b0000, 4'b0000, 4'b1000, 4'b0000);
    rd(3, 5); cyc("R5", 4'b1000, 4'b1000, 4'b0000, 4'b0000);
    wr(3, 5); cyc("R5", 4'b0000, 4'b0000, 4'b0000, 4'b0000);
  endtask

  task automatic t_independent();
    rd(0, 1); rd(1, 2); cyc("R10", 4'b0011, 4'b0011, 4'b0000, 4'b0000);
    rd(2, 1); cyc("R10", 4'b0100, 4'b0000, 4'b0000, 4'b0000);
    wr(1, 2); cyc("R10", 4'b0000, 4'b0000, 4'b0000, 4'b0000);
    wr(0, 1); cyc("R10", 4'b0000, 4'b0000, 4'b0100, 4'b0000);
    rd(2, 1); cyc("R10", 4'b0100, 4'b0100, 4'b0000, 4'b0000);
    wr(2, 1); cyc("R10", 4'b0000, 4'b0000, 4'b0000, 4'b0000);
  endtask

  task automatic t_free_store();
    wr(2, 6); cyc("R7", 4'b0000, 4'b0000, 4'b0000, 4'b0100);
    rd(3, 6); cyc("R7", 4'b1000, 4'b1000, 4'b0000, 4'b0000);
    wr(3, 6); cyc("R7", 4'b0000, 4'b0000, 4'b0000, 4'b0000);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_hold_and_wake();
    t_wrap_and_steal();
    t_tie();
    t_independent();
    t_free_store();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule